// File: doc/BRIEF.md
# Consumer-Electronics-Control Transmit Request Sequencer

This block holds the three-bit control word of a single-wire consumer-electronics-control bus peripheral and turns a software transmit request into one start pulse for the bit-level line engine. Software enables the peripheral, optionally marks the message as ending, and then raises a start request. The block waits for the bus to be quiet. A reception in progress or a busy line holds it off. It then counts a signal-free interval of `SFT_CYCLES` clocks and pulses `tx_start`.

The line engine answers with outcome strobes. Success, underrun, negative acknowledge and transmit error retire the request: both request bits drop together. Arbitration loss keeps the request and runs the quiet-time count again, so the start is retried without software help. The start bit reads back as a busy flag for as long as a request is open. A write that clears the enable bit wipes the whole control word at once and emits a one-cycle abort to the receiver and transmitter.

Top module: `cec_txreq_ctrl`

## Requirements
- R1: After reset `reg_rdata` is 0, and `tx_start`, `tx_ping` and `tx_abort` are low.
- R2: Control word layout: bit 0 enable, bit 1 start request, bit 2 end marker. A write whose enable bit is 1 sets enable. While the stored enable is 0, the request bits of a write are ignored, and a write of 0x7 then reads back 0x1.
- R3: The start-request bit reads 1 from the edge that accepts its write until the edge at which an outcome strobe or a disable write clears it. `tx_start` is only ever high while it reads 1.
- R4: With the line and receiver idle, `tx_start` is high for exactly one cycle. That cycle follows the `SFT_CYCLES`-th clock edge after the edge that accepts the request write.
- R5: `line_busy` sampled high restarts the quiet count. `tx_start` then follows the `SFT_CYCLES`-th edge after the last edge at which `line_busy` was high.
- R6: A request made while `rx_busy` is high produces no `tx_start` until `rx_busy` falls. It then starts after `SFT_CYCLES` edges, counted as in R5.
- R7: Once `tx_start` has been issued, a pulse on `tx_done_ok`, `tx_underrun`, `tx_nack` or `tx_error` clears both request bits at that edge, leaving enable set.
- R8: Once `tx_start` has been issued, a pulse on `tx_arb_lost` with no other outcome leaves both request bits set. `tx_start` pulses again `SFT_CYCLES` edges after the strobe edge.
- R9: A write with bit 0 at 0 makes `reg_rdata` read 0 after that edge and raises `tx_abort` for exactly one cycle. No `tx_start` follows while the block stays disabled.
- R10: `tx_ping` is high together with `tx_start` exactly when the end marker was set before the request, or in the same write. A request whose end marker comes later gives `tx_start` with `tx_ping` low.
- R11: An outcome strobe in the same cycle as a software write that sets the request bits clears them. Clearing wins over setting.
- R12: Outcome strobes before `tx_start` has been issued are ignored. The request stays set and the start still follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data; bits 2:0 used |
| reg_rdata | output | 32 | Control word readback |
| rx_busy | input | 1 | Receiver is taking in a message |
| line_busy | input | 1 | Bus line seen active |
| tx_done_ok | input | 1 | Last byte acknowledged |
| tx_underrun | input | 1 | Transmit data ran dry |
| tx_nack | input | 1 | Negative acknowledge |
| tx_error | input | 1 | Transmit bit error |
| tx_arb_lost | input | 1 | Arbitration lost |
| tx_start | output | 1 | One-cycle start command to the line engine |
| tx_ping | output | 1 | The started message is a header-only ping |
| tx_abort | output | 1 | One-cycle abort on disable |
| rx_enable | output | 1 | Receiver enable |

## Verification
Two things can hit the request bits on the same edge: the hardware clear from an outcome strobe and a software write that sets them. The bench starts a transmission, then asserts `tx_done_ok` together with a write of 0x7 in the same cycle. It judges the result by reading back 0x1, with no further start. A second case lands a disable write on top of an open request. A third checks that early outcome strobes never retire a request that has not yet started.

// File: rtl/cec_txreq_ctrl.sv
module cec_txreq_ctrl #(
  parameter int SFT_CYCLES = 8,
  localparam int CW = (SFT_CYCLES > 1) ? $clog2(SFT_CYCLES) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_busy,
  input  logic        line_busy,
  input  logic        tx_done_ok,
  input  logic        tx_underrun,
  input  logic        tx_nack,
  input  logic        tx_error,
  input  logic        tx_arb_lost,
  output logic        tx_start,
  output logic        tx_ping,
  output logic        tx_abort,
  output logic        rx_enable
);

  typedef enum logic [1:0] {S_IDLE, S_COUNT, S_SEND} seq_t;

  seq_t          st;
  logic [CW-1:0] cnt;
  logic          en_q, som_q, eom_q, ping_q, abort_q;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[31:3];

  wire dis_wr  = reg_wr & ~reg_wdata[0];
  wire keep_wr = reg_wr &  reg_wdata[0];
  wire busy    = rx_busy | line_busy;
  wire in_send = (st == S_SEND);
  wire finish  = in_send & (tx_done_ok | tx_underrun | tx_nack | tx_error);
  wire retry   = in_send & tx_arb_lost & ~finish;
  wire som_new = keep_wr & en_q & reg_wdata[1] & ~som_q;
  wire eom_set = keep_wr & en_q & reg_wdata[2];

  assign tx_start  = (st == S_COUNT) & ~busy & (cnt == CW'(SFT_CYCLES - 1));
  assign tx_ping   = tx_start & ping_q;
  assign tx_abort  = abort_q;
  assign rx_enable = en_q;
  assign reg_rdata = {29'd0, eom_q, som_q, en_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      som_q   <= 1'b0;
      eom_q   <= 1'b0;
      ping_q  <= 1'b0;
      abort_q <= 1'b0;
      st      <= S_IDLE;
      cnt     <= '0;
    end else if (dis_wr) begin
      en_q    <= 1'b0;
      som_q   <= 1'b0;
      eom_q   <= 1'b0;
      ping_q  <= 1'b0;
      abort_q <= 1'b1;
      st      <= S_IDLE;
      cnt     <= '0;
    end else begin
      abort_q <= 1'b0;
      if (keep_wr) en_q <= 1'b1;

      if (finish) begin
        som_q  <= 1'b0;
        eom_q  <= 1'b0;
        ping_q <= 1'b0;
      end else begin
        if (som_new) begin
          som_q  <= 1'b1;
          ping_q <= eom_q | eom_set;
        end
        if (eom_set) eom_q <= 1'b1;
      end

      case (st)
        S_IDLE: begin
          if (som_q && !busy) begin
            st  <= S_COUNT;
            cnt <= '0;
          end
        end
        S_COUNT: begin
          if (busy)          st  <= S_IDLE;
          else if (tx_start) st  <= S_SEND;
          else               cnt <= cnt + CW'(1);
        end
        S_SEND: begin
          if (finish || retry) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module cec_txreq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        tx_done_ok,
  input logic        tx_underrun,
  input logic        tx_nack,
  input logic        tx_error,
  input logic        tx_arb_lost,
  input logic        tx_start,
  input logic        tx_ping,
  input logic        tx_abort
);

  wire any_end = tx_done_ok | tx_underrun | tx_nack | tx_error;

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[0]) |=> (reg_rdata[2:0] == 3'b000 && tx_abort));

  // R2
  ignore_som_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rdata[0]) |=> (!reg_rdata[1] && !reg_rdata[2]));

  // R3
  start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> reg_rdata[1]);

  // R3
  som_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[1]) |-> ($past(reg_wr && !reg_wdata[0]) || $past(any_end)));

  // R8
  arb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_arb_lost && reg_rdata[1] && !any_end && !reg_wr) |=> reg_rdata[1]);

  // R10
  ping_eom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ping |-> reg_rdata[2]);

endmodule

bind cec_txreq_ctrl cec_txreq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .tx_done_ok(tx_done_ok), .tx_underrun(tx_underrun),
  .tx_nack(tx_nack), .tx_error(tx_error), .tx_arb_lost(tx_arb_lost),
  .tx_start(tx_start), .tx_ping(tx_ping), .tx_abort(tx_abort)
);

// File: tb/cec_txreq_ctrl_bench.sv
module cec_txreq_ctrl_bench;
  localparam int SFT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_busy = 1'b0, line_busy = 1'b0;
  logic        tx_done_ok = 1'b0, tx_underrun = 1'b0, tx_nack = 1'b0;
  logic        tx_error = 1'b0, tx_arb_lost = 1'b0;
  logic        tx_start, tx_ping, tx_abort, rx_enable;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  cec_txreq_ctrl #(.SFT_CYCLES(SFT)) u_cec_txreq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_busy(rx_busy), .line_busy(line_busy),
    .tx_done_ok(tx_done_ok), .tx_underrun(tx_underrun), .tx_nack(tx_nack),
    .tx_error(tx_error), .tx_arb_lost(tx_arb_lost), .tx_start(tx_start),
    .tx_ping(tx_ping), .tx_abort(tx_abort), .rx_enable(rx_enable)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // which: 0 done, 1 underrun, 2 nack, 3 error, 4 arb lost
  task automatic strobe(input int which);
    @(negedge clk);
    tx_done_ok = (which == 0); tx_underrun = (which == 1);
    tx_nack = (which == 2); tx_error = (which == 3); tx_arb_lost = (which == 4);
    @(negedge clk);
    {tx_done_ok, tx_underrun, tx_nack, tx_error, tx_arb_lost} = '0;
  endtask

  task automatic wait_start(output int k, output bit ping);
    k = -1; ping = 1'b0;
    for (int i = 1; i <= 60; i++) begin
      @(posedge clk); @(negedge clk);
      if (tx_start) begin k = i; ping = tx_ping; break; end
    end
  endtask

  task automatic no_start(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_start) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset();
    chk(reg_rdata == 0, "R1", reg_rdata, 0);
    chk(!tx_start && !tx_ping && !tx_abort, "R1", {tx_start, tx_ping, tx_abort}, 0);
  endtask

  task automatic t_disabled_ignore();
    wr(32'h6);
    chk(reg_rdata == 0, "R2", reg_rdata, 0);
    wr(32'h7);
    chk(reg_rdata == 1, "R2", reg_rdata, 1);
    no_start(SFT + 4, "R2");
  endtask

  task automatic t_basic();
    int k; bit p;
    wr(32'h3);
    chk(reg_rdata == 3, "R3", reg_rdata, 3);
    wait_start(k, p);
    chk(k == SFT, "R4", k, SFT);
    chk(p == 1'b0, "R10", p, 0);
    @(negedge clk);
    chk(!tx_start, "R4", tx_start, 0);
    chk(reg_rdata == 3, "R3", reg_rdata, 3);
    wr(32'h5);
    chk(reg_rdata == 7, "R2", reg_rdata, 7);
    strobe(0);
    chk(reg_rdata == 1, "R7", reg_rdata, 1);
  endtask

  task automatic t_outcome(input int which);
    int k; bit p;
    wr(32'h3);
    wait_start(k, p);
    chk(k == SFT, "R4", k, SFT);
    strobe(which);
    chk(reg_rdata == 1, "R7", reg_rdata, 1);
    no_start(SFT + 3, "R7");
  endtask

  task automatic t_ping();
    int k; bit p;
    wr(32'h5);
    wr(32'h3);
    wait_start(k, p);
    chk(k == SFT && p, "R10", p, 1);
    strobe(0);
    chk(reg_rdata == 1, "R7", reg_rdata, 1);
  endtask

  task automatic t_line_busy();
    int k; bit p;
    wr(32'h3);
    @(negedge clk); line_busy = 1'b1;
    repeat (4) @(negedge clk);
    line_busy = 1'b0;
    wait_start(k, p);
    chk(k == SFT, "R5", k, SFT);
    strobe(0);
  endtask

  task automatic t_rx_hold();
    int k; bit p;
    @(negedge clk); rx_busy = 1'b1;
    wr(32'h3);
    no_start(3 * SFT, "R6");
    chk(reg_rdata == 3, "R6", reg_rdata, 3);
    rx_busy = 1'b0;
    wait_start(k, p);
    chk(k == SFT, "R6", k, SFT);
    strobe(0);
  endtask

  task automatic t_arb();
    int k; bit p;
    wr(32'h5);
    wr(32'h3);
    wait_start(k, p);
    strobe(4);
    chk(reg_rdata == 7, "R8", reg_rdata, 7);
    wait_start(k, p);
    chk(k == SFT, "R8", k, SFT);
    chk(p == 1'b1, "R10", p, 1);
    strobe(0);
    chk(reg_rdata == 1, "R7", reg_rdata, 1);
  endtask

  task automatic t_early_strobe();
    int k; bit p;
    wr(32'h3);
    strobe(0);
    strobe(2);
    chk(reg_rdata == 3, "R12", reg_rdata, 3);
    wait_start(k, p);
    chk(k > 0, "R12", k, 1);
    strobe(0);
  endtask

  task automatic t_disable();
    int k; bit p;
    wr(32'h3);
    wait_start(k, p);
    wr(32'h0);
    chk(reg_rdata == 0, "R9", reg_rdata, 0);
    chk(tx_abort == 1'b1, "R9", tx_abort, 1);
    @(negedge clk);
    chk(tx_abort == 1'b0, "R9", tx_abort, 0);
    chk(rx_enable == 1'b0, "R9", rx_enable, 0);
    no_start(SFT + 4, "R9");
    wr(32'h1);
  endtask

  task automatic t_collision();
    int k; bit p;
    wr(32'h3);
    wait_start(k, p);
    @(negedge clk);
    tx_done_ok = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h7;
    @(negedge clk);
    tx_done_ok = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    chk(reg_rdata == 1, "R11", reg_rdata, 1);
    no_start(SFT + 3, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_ignore();
    t_basic();
    for (int w = 1; w < 4; w++) t_outcome(w);
    t_ping();
    t_line_busy();
    t_rx_hold();
    t_arb();
    t_early_strobe();
    t_disable();
    t_collision();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule